// File: doc/BRIEF.md
# Memory-to-Memory Subtract-and-Branch Processor

This block is a small multi-cycle processor with a single instruction. Each instruction occupies three consecutive 32-bit memory words. The first word holds the address of the subtrahend. The second holds the address of the minuend, which is also where the result goes. The third holds the jump target. The core subtracts the first operand from the second, writes the difference back over the second operand, and jumps to the target when the difference is negative. Otherwise it falls through to the next instruction, three words further on. Clearing a word, moving data and unconditional jumps are all built from this one operation.

The datapath has a program counter, a memory address register, and the registered read port of an internal synchronous RAM, which acts as the memory data register. It also has an operand register that holds the subtrahend and one adder whose second input can be inverted, with a carry-in. The same adder produces the difference and the program-counter increments. A control state machine steps through twelve states per instruction and allows one memory access per cycle. The program and data are written into the RAM through a load port while reset is held. A combinational peek port reads any word at any time. A program stops itself by executing an instruction whose target is its own address.

Top module: `sbn_cpu`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, `pc_out` becomes 0, and `halted`, `flag_n` and `flag_z` become 0.
- R2: While `rst_n` is low, a rising edge with `load_we` high writes `load_data` to word `load_addr`. While `rst_n` is high, `load_we` has no effect on memory. `peek_data` always shows the word at `peek_addr` with no clock delay.
- R3: An instruction at address P reads word P as address A and word P+1 as address B. It then writes mem[B] − mem[A] into mem[B], using two's-complement arithmetic modulo 2^32. Word A is left unchanged unless A equals B.
- R4: If bit 31 of the difference is 1, the next instruction address becomes the low 8 bits of word P+2. Otherwise it becomes P+3, modulo 256. A zero difference counts as not negative.
- R5: When A equals B, the addressed word becomes 0 and the branch is not taken.
- R6: After each instruction, `flag_n` equals bit 31 of its difference, and `flag_z` is 1 exactly when the difference is zero.
- R7: An instruction whose target word equals its own address P still performs its write. After that, `halted` rises and stays high, `pc_out` holds P, and the core makes no further memory writes. This applies whether or not the branch would have been taken.
- R8: Every instruction takes exactly 12 clock cycles. `halted` is first seen high 12·k rising edges after `rst_n` rises, where k is the number of instructions executed, counting the halting one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; also enables the load port |
| load_we | input | 1 | Write strobe for the load port |
| load_addr | input | 8 | Word address for the load port |
| load_data | input | 32 | Data for the load port |
| peek_addr | input | 8 | Word address for the peek port |
| peek_data | output | 32 | Combinational contents of the word at `peek_addr` |
| pc_out | output | 8 | Address of the current instruction |
| halted | output | 1 | High once a self-targeting instruction has completed |
| flag_n | output | 1 | Sign of the last difference |
| flag_z | output | 1 | Last difference was zero |

## Verification
Operand pairs are chosen to separate a positive difference from a negative one and from an exact zero. The zero case must fall through like the positive case, which exposes a branch on "less than or equal". Pairs near the signed extremes, such as the most negative word minus zero and the same word minus one, show that the branch follows bit 31 of the wrapped result and not a true signed comparison. A same-address instruction, a countdown loop that runs through several taken and untaken branches, and a halt on a taken self-branch cover clearing, sequencing and stopping. Cycle counts to `halted` confirm the twelve-cycle instruction length.

// File: rtl/sbn_pkg.sv
// Package: shared types for the subtract-and-branch processor.
// Assumes: consumers import the state and select encodings by name only.
package sbn_pkg;

    // Control sequence states, one memory access per cycle.
    typedef enum logic [3:0] {
        ST_FETCH_SRC1,
        ST_WAIT_SRC1,
        ST_PTR_SRC1,
        ST_WAIT_OPA,
        ST_TAKE_OPA,
        ST_WAIT_SRC2,
        ST_PTR_SRC2,
        ST_WAIT_OPB,
        ST_EXEC,
        ST_FETCH_TGT,
        ST_WAIT_TGT,
        ST_BRANCH,
        ST_HALT
    } cpu_state_e;

    // Source of the memory address register.
    typedef enum logic [1:0] {
        MAR_FROM_PC,
        MAR_FROM_MDR,
        MAR_FROM_ADDER
    } mar_sel_e;

    // Adder operation selected by the controller.
    typedef enum logic [1:0] {
        ALU_SUB,
        ALU_INC1,
        ALU_INC2,
        ALU_INC3
    } alu_op_e;

    // Next program-counter source.
    typedef enum logic [1:0] {
        PC_HOLD,
        PC_FROM_TARGET,
        PC_FROM_ADDER
    } pc_sel_e;

endpackage

// File: rtl/sbn_adder.sv
// Module: sbn_adder
// What: a two-input adder with an optional inversion of the second operand
//       and a carry-in, producing the sum and its sign and zero indications.
// Assumes: subtraction is requested as inv_b=1, cin=1 (a - b).
module sbn_adder #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         inv_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         neg,
    output logic         zero
);

    logic [W-1:0] b_eff;

    // Operand conditioning and addition.
    always_comb begin
        b_eff = inv_b ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, cin};
        neg   = sum[W-1];
        zero  = (sum == '0);
    end

endmodule

// File: rtl/sbn_ram.sv
// Module: sbn_ram
// What: single-write, registered-read word memory with an extra
//       combinational observation port.
// Assumes: depth is 2**AW; the read register is the processor's data register.
module sbn_ram #(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata,
    input  logic [AW-1:0] peek_addr,
    output logic [W-1:0]  peek_data
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Synchronous write and registered read.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

    // Combinational observation read.
    always_comb begin
        peek_data = mem[peek_addr];
    end

endmodule

// File: rtl/sbn_ctrl.sv
// Module: sbn_ctrl
// What: sequencing state machine; twelve states per instruction plus a
//       terminal halt state, issuing register loads and selects.
// Assumes: flag_n was captured in ST_EXEC; halt_hit compares the fetched
//          target with the current instruction address during ST_BRANCH.
module sbn_ctrl
    import sbn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flag_n,
    input  logic       halt_hit,
    output cpu_state_e state,
    output mar_sel_e   mar_sel,
    output logic       ld_mar,
    output logic       ld_r,
    output logic       ld_flags,
    output logic       core_we,
    output alu_op_e    alu_op,
    output pc_sel_e    pc_sel
);

    cpu_state_e state_nx;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH_SRC1;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state and control decode.
    always_comb begin
        state_nx = state;
        mar_sel  = MAR_FROM_PC;
        ld_mar   = 1'b0;
        ld_r     = 1'b0;
        ld_flags = 1'b0;
        core_we  = 1'b0;
        alu_op   = ALU_INC1;
        pc_sel   = PC_HOLD;
        unique case (state)
            ST_FETCH_SRC1: begin
                ld_mar   = 1'b1;
                mar_sel  = MAR_FROM_PC;
                state_nx = ST_WAIT_SRC1;
            end
            ST_WAIT_SRC1: state_nx = ST_PTR_SRC1;
            ST_PTR_SRC1: begin
                ld_mar   = 1'b1;
                mar_sel  = MAR_FROM_MDR;
                state_nx = ST_WAIT_OPA;
            end
            ST_WAIT_OPA: state_nx = ST_TAKE_OPA;
            ST_TAKE_OPA: begin
                ld_r     = 1'b1;
                ld_mar   = 1'b1;
                mar_sel  = MAR_FROM_ADDER;
                alu_op   = ALU_INC1;
                state_nx = ST_WAIT_SRC2;
            end
            ST_WAIT_SRC2: state_nx = ST_PTR_SRC2;
            ST_PTR_SRC2: begin
                ld_mar   = 1'b1;
                mar_sel  = MAR_FROM_MDR;
                state_nx = ST_WAIT_OPB;
            end
            ST_WAIT_OPB: state_nx = ST_EXEC;
            ST_EXEC: begin
                alu_op   = ALU_SUB;
                core_we  = 1'b1;
                ld_flags = 1'b1;
                state_nx = ST_FETCH_TGT;
            end
            ST_FETCH_TGT: begin
                ld_mar   = 1'b1;
                mar_sel  = MAR_FROM_ADDER;
                alu_op   = ALU_INC2;
                state_nx = ST_WAIT_TGT;
            end
            ST_WAIT_TGT: state_nx = ST_BRANCH;
            ST_BRANCH: begin
                alu_op = ALU_INC3;
                if (halt_hit) begin
                    state_nx = ST_HALT;
                end else begin
                    pc_sel   = flag_n ? PC_FROM_TARGET : PC_FROM_ADDER;
                    state_nx = ST_FETCH_SRC1;
                end
            end
            ST_HALT: state_nx = ST_HALT;
            default: state_nx = ST_FETCH_SRC1;
        endcase
    end

endmodule

// File: rtl/sbn_cpu.sv
// Module: sbn_cpu (top)
// What: single-instruction processor. Datapath registers (PC, MAR, operand
//       register R, N/Z flags) around one complementing adder and a RAM
//       whose read register serves as the data register.
// Assumes: memory is loaded through the load port while rst_n is low;
//          address words use their low ADDR_W bits.
module sbn_cpu #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_we,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [WORD_W-1:0] load_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [WORD_W-1:0] peek_data,
    output logic [ADDR_W-1:0] pc_out,
    output logic              halted,
    output logic              flag_n,
    output logic              flag_z
);

    import sbn_pkg::*;

    localparam int unsigned PAD_W = WORD_W - ADDR_W;

    cpu_state_e        state;
    mar_sel_e          mar_sel;
    alu_op_e           alu_op;
    pc_sel_e           pc_sel;
    logic              ld_mar;
    logic              ld_r;
    logic              ld_flags;
    logic              core_we;
    logic              halt_hit;

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [WORD_W-1:0] r_q;
    logic [WORD_W-1:0] mdr;
    logic              n_q;
    logic              z_q;

    logic [WORD_W-1:0] add_a;
    logic [WORD_W-1:0] add_b;
    logic              add_inv;
    logic              add_cin;
    logic [WORD_W-1:0] adder_sum;
    logic              adder_neg;
    logic              adder_zero;

    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [WORD_W-1:0] ram_wdata;

    sbn_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_n   (n_q),
        .halt_hit (halt_hit),
        .state    (state),
        .mar_sel  (mar_sel),
        .ld_mar   (ld_mar),
        .ld_r     (ld_r),
        .ld_flags (ld_flags),
        .core_we  (core_we),
        .alu_op   (alu_op),
        .pc_sel   (pc_sel)
    );

    // Adder operand routing per requested operation.
    always_comb begin
        add_a   = {{PAD_W{1'b0}}, pc_q};
        add_b   = '0;
        add_inv = 1'b0;
        add_cin = 1'b1;
        unique case (alu_op)
            ALU_SUB: begin
                add_a   = mdr;
                add_b   = r_q;
                add_inv = 1'b1;
            end
            ALU_INC1: add_b = '0;
            ALU_INC2: add_b = {{(WORD_W-1){1'b0}}, 1'b1};
            ALU_INC3: add_b = {{(WORD_W-2){1'b0}}, 2'd2};
            default:  add_b = '0;
        endcase
    end

    sbn_adder #(.W(WORD_W)) u_adder (
        .a     (add_a),
        .b     (add_b),
        .inv_b (add_inv),
        .cin   (add_cin),
        .sum   (adder_sum),
        .neg   (adder_neg),
        .zero  (adder_zero)
    );

    // Halt detection: fetched target equals the current instruction address.
    always_comb begin
        halt_hit = (mdr[ADDR_W-1:0] == pc_q);
    end

    // Memory write arbitration: load port only while reset is held.
    always_comb begin
        if (!rst_n) begin
            ram_we    = load_we;
            ram_waddr = load_addr;
            ram_wdata = load_data;
        end else begin
            ram_we    = core_we;
            ram_waddr = mar_q;
            ram_wdata = adder_sum;
        end
    end

    sbn_ram #(.W(WORD_W), .AW(ADDR_W)) u_ram (
        .clk       (clk),
        .we        (ram_we),
        .waddr     (ram_waddr),
        .wdata     (ram_wdata),
        .raddr     (mar_q),
        .rdata     (mdr),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

    // Program counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            unique case (pc_sel)
                PC_FROM_TARGET: pc_q <= mdr[ADDR_W-1:0];
                PC_FROM_ADDER:  pc_q <= adder_sum[ADDR_W-1:0];
                default:        pc_q <= pc_q;
            endcase
        end
    end

    // Memory address register load from the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
        end else if (ld_mar) begin
            unique case (mar_sel)
                MAR_FROM_MDR:   mar_q <= mdr[ADDR_W-1:0];
                MAR_FROM_ADDER: mar_q <= adder_sum[ADDR_W-1:0];
                default:        mar_q <= pc_q;
            endcase
        end
    end

    // Operand register and condition flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
            n_q <= 1'b0;
            z_q <= 1'b0;
        end else begin
            if (ld_r) begin
                r_q <= mdr;
            end
            if (ld_flags) begin
                n_q <= adder_neg;
                z_q <= adder_zero;
            end
        end
    end

    // Output mapping.
    always_comb begin
        pc_out = pc_q;
        halted = (state == ST_HALT);
        flag_n = n_q;
        flag_z = z_q;
    end

endmodule

// File: rtl/sbn_cpu_chk.sv
// Module: sbn_cpu_chk
// What: temporal checks on the processor, attached to every sbn_cpu by bind.
// Assumes: rst_n is driven low from time zero.
module sbn_cpu_chk
    import sbn_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halted,
    input logic [ADDR_W-1:0] pc_out,
    input logic              flag_n,
    input logic              flag_z,
    input logic              core_we,
    input logic [WORD_W-1:0] core_wdata,
    input cpu_state_e        state
);

    // R1: reset clears the visible state.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pc_out == '0 && !halted && !flag_n && !flag_z));

    // R6: flags follow the difference just written.
    p_flags_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        core_we |=> (flag_n == $past(core_wdata[WORD_W-1]) &&
                     flag_z == ($past(core_wdata) == '0)));

    // R7: halt is permanent.
    p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R7: nothing moves and nothing is written once halted.
    p_halt_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(pc_out) && !core_we));

    // R8: one write per instruction, never on consecutive cycles.
    p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        core_we |=> !core_we);

    // R4: the instruction address changes only on leaving the branch step.
    p_pc_branch_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_out != $past(pc_out)) |-> ($past(state) == ST_BRANCH));

endmodule

bind sbn_cpu sbn_cpu_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_sbn_cpu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halted     (halted),
    .pc_out     (pc_out),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .core_we    (core_we),
    .core_wdata (adder_sum),
    .state      (state)
);

// File: tb/sbn_cpu_bench.sv
// Bench for sbn_cpu: a table of operand pairs run through a two-instruction
// program, then directed programs for clearing, looping, self-branch halt,
// the load port while running, and reset.
module sbn_cpu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_we = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [7:0]  peek_addr = '0;
    logic [31:0] peek_data;
    logic [7:0]  pc_out;
    logic        halted;
    logic        flag_n;
    logic        flag_z;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    localparam int NVEC = 8;
    localparam logic [31:0] VEC_A [NVEC] = '{
        32'd5, 32'd12, 32'd7, 32'd0, 32'd1, 32'hFFFF_FFFF, 32'd0, 32'h1234_5678};
    localparam logic [31:0] VEC_B [NVEC] = '{
        32'd12, 32'd5, 32'd7, 32'h8000_0000, 32'h8000_0000, 32'd0, 32'd0, 32'h0F0F_0F0F};

    sbn_cpu u_sbn_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_we   (load_we),
        .load_addr (load_addr),
        .load_data (load_data),
        .peek_addr (peek_addr),
        .peek_data (peek_data),
        .pc_out    (pc_out),
        .halted    (halted),
        .flag_n    (flag_n),
        .flag_z    (flag_z)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks + 1, n_fails + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic poke(input logic [7:0] a, input logic [31:0] d);
        load_we = 1'b1; load_addr = a; load_data = d;
        tick();
        load_we = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        peek_addr = a;
        #1;
        d = peek_data;
    endtask

    task automatic put_instr(input logic [7:0] at, input logic [7:0] a, input logic [7:0] b, input logic [7:0] t);
        poke(at, {24'd0, a});
        poke(at + 8'd1, {24'd0, b});
        poke(at + 8'd2, {24'd0, t});
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        tick();
        tick();
    endtask

    // Release reset and count rising edges until halted is seen.
    task automatic run(output int n);
        n = 0;
        rst_n = 1'b1;
        while (!halted && n < 5000) begin
            tick();
            n++;
        end
    endtask

    initial begin
        logic [31:0] w;
        logic [31:0] exp_d;
        int n;
        @(negedge clk);
        hold_reset();

        // R1: reset state.
        check(pc_out == 8'd0, "R1 pc", {24'd0, pc_out}, 32'd0);
        check(!halted && !flag_n && !flag_z, "R1 status", {29'd0, halted, flag_n, flag_z}, 32'd0);

        // Table walk: program 0:(100,101,6) 3:(102,102,3) 6:(102,102,6).
        for (int i = 0; i < NVEC; i++) begin
            hold_reset();
            put_instr(8'd0, 8'd100, 8'd101, 8'd6);
            put_instr(8'd3, 8'd102, 8'd102, 8'd3);
            put_instr(8'd6, 8'd102, 8'd102, 8'd6);
            poke(8'd100, VEC_A[i]);
            poke(8'd101, VEC_B[i]);
            poke(8'd102, 32'h0000_00AA);
            run(n);
            exp_d = VEC_B[i] - VEC_A[i];
            peek(8'd101, w);
            check(w == exp_d, "R3 difference", w, exp_d);
            peek(8'd100, w);
            check(w == VEC_A[i], "R3 subtrahend kept", w, VEC_A[i]);
            check(pc_out == (exp_d[31] ? 8'd6 : 8'd3), "R4 branch select", {24'd0, pc_out},
                  exp_d[31] ? 32'd6 : 32'd3);
            check(n == 24, "R8 two-instruction length", n, 32'd24);
            check(flag_z && !flag_n, "R6 flags after clear", {30'd0, flag_n, flag_z}, 32'd1);
        end

        // R5: same address clears and falls through; target is self so R7 halts at 0.
        hold_reset();
        put_instr(8'd0, 8'd110, 8'd110, 8'd0);
        poke(8'd110, 32'h0000_0055);
        run(n);
        peek(8'd110, w);
        check(w == 32'd0, "R5 self clear", w, 32'd0);
        check(halted && pc_out == 8'd0, "R7 halt pc", {24'd0, pc_out}, 32'd0);
        check(n == 12, "R8 single-instruction length", n, 32'd12);

        // R6/R7: taken self-branch halts with negative flags.
        hold_reset();
        put_instr(8'd0, 8'd107, 8'd108, 8'd0);
        poke(8'd107, 32'd1);
        poke(8'd108, 32'd0);
        run(n);
        peek(8'd108, w);
        check(w == 32'hFFFF_FFFF, "R3 wrap to minus one", w, 32'hFFFF_FFFF);
        check(flag_n && !flag_z, "R6 negative flags", {30'd0, flag_n, flag_z}, 32'd2);
        check(halted && pc_out == 8'd0, "R7 taken self halt", {24'd0, pc_out}, 32'd0);
        repeat (30) tick();
        check(halted && pc_out == 8'd0, "R7 halt held", {31'd0, halted}, 32'd1);
        peek(8'd108, w);
        check(w == 32'hFFFF_FFFF, "R7 no write after halt", w, 32'hFFFF_FFFF);

        // R2: load port ignored while running.
        load_we = 1'b1; load_addr = 8'd108; load_data = 32'hDEAD_BEEF;
        tick();
        load_we = 1'b0;
        peek(8'd108, w);
        check(w == 32'hFFFF_FFFF, "R2 load ignored when running", w, 32'hFFFF_FFFF);

        // Countdown loop: 0:(100,101,6) 3:(103,104,0) 6:(105,105,6).
        hold_reset();
        put_instr(8'd0, 8'd100, 8'd101, 8'd6);
        put_instr(8'd3, 8'd103, 8'd104, 8'd0);
        put_instr(8'd6, 8'd105, 8'd105, 8'd6);
        poke(8'd100, 32'd3);
        poke(8'd101, 32'd10);
        poke(8'd103, 32'd0);
        poke(8'd104, 32'h8000_0000);
        run(n);
        peek(8'd101, w);
        check(w == 32'hFFFF_FFFE, "R3 loop result", w, 32'hFFFF_FFFE);
        check(pc_out == 8'd6, "R4 loop exit", {24'd0, pc_out}, 32'd6);
        check(n == 96, "R8 eight-instruction length", n, 32'd96);
        peek(8'd104, w);
        check(w == 32'h8000_0000, "R3 subtract zero", w, 32'h8000_0000);

        // R2: load port writes during reset.
        hold_reset();
        poke(8'd200, 32'hCAFE_0001);
        peek(8'd200, w);
        check(w == 32'hCAFE_0001, "R2 load in reset", w, 32'hCAFE_0001);

        // R1: reset after a halt clears everything.
        check(pc_out == 8'd0 && !halted, "R1 reset after halt", {24'd0, pc_out}, 32'd0);
        check(!flag_n && !flag_z, "R1 flags after halt", {30'd0, flag_n, flag_z}, 32'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule